// File: doc/BRIEF.md
# Dual-Accumulator Arithmetic Register Datapath

This block holds the working registers of a small 8-bit accumulator machine: two 8-bit accumulators A and B, a 16-bit view of the pair, two 16-bit index registers X and Y, and an 8-bit flag register. On a clock edge where the operation strobe is high, it performs one register-to-register operation chosen by a 3-bit select. The operations are add, subtract and compare of the accumulator pair, adding B into an index register, moving A to or from the flags, and decimal adjust of A after a BCD add.

The operation set is lopsided on purpose. Index additions only take B. Flag transfers and decimal adjust only touch A. Pair arithmetic always leaves its result in A. A combinational port forms an indexed effective address from X or Y plus an unsigned 8-bit offset. A parallel load port lets a test environment set any register directly. Instruction decode, memory, stack and interrupts are handled elsewhere.

Top module: `dualacc_datapath`

## Requirements
- R1: While rst_n is low, on each clock A, B, X and Y become zero and the flag register becomes 0xD0. The flag layout from bit 7 to bit 0 is: stop-disable, X-mask, half-carry H, I-mask, negative N, zero Z, overflow V, carry C.
- R2: acc_d always equals {acc_a, acc_b}. Loading the double register (ld_sel 2) writes bits 15:8 to A and bits 7:0 to B.
- R3: op_sel 0 sets A = A + B mod 256. It sets N and Z from the result, V to the signed overflow, C to the carry out of bit 7 and H to the carry out of bit 3. The I, X and S bits are kept.
- R4: op_sel 1 sets A = A − B mod 256. It sets N, Z, V, and sets C to the borrow (A < B unsigned). H is kept.
- R5: op_sel 2 updates N, Z, V and C exactly as subtract would, and leaves A and B unchanged.
- R6: op_sel 3 sets X = X + B and op_sel 4 sets Y = Y + B. B is unsigned and the sum wraps mod 65536. The flag register is unchanged.
- R7: op_sel 5 copies A into the flag register, except that bit 6 becomes (old bit 6 AND A[6]). A transfer can clear the X-mask but never set it.
- R8: op_sel 6 copies the flag register into A and leaves the flags unchanged.
- R9: op_sel 7 adds 0x06 to A when H=1 or the low nibble is above 9. It adds 0x60 when C=1, or the high nibble is above 9, or the high nibble is above 8 with the low nibble above 9. C becomes 1 exactly when 0x60 was added. N and Z follow the result. H and V are kept.
- R10: ea_addr = (ea_sel ? Y : X) + ea_offset, with the offset unsigned and the sum wrapping mod 65536. The output is combinational from the current register values.
- R11: With ld_en high, ld_sel selects the target: 0 A, 1 B, 2 D, 3 X, 4 Y, 5 flags (all 8 bits written directly). A and B take ld_data[7:0]. Codes 6 and 7 change nothing. A load takes priority over a strobe in the same cycle, and that strobe is ignored.
- R12: In a cycle with neither ld_en nor op_valid, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation select (see R3–R9) |
| ld_en | input | 1 | Parallel load enable |
| ld_sel | input | 3 | Load target select |
| ld_data | input | 16 | Load data |
| ea_sel | input | 1 | Index select for address: 0 X, 1 Y |
| ea_offset | input | 8 | Unsigned address offset |
| ea_addr | output | 16 | Effective address |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| acc_d | output | 16 | Double accumulator {A,B} |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| ccr | output | 8 | Flag register |

## Verification
The hardest decimal-adjust cases depend on the half-carry and carry left behind by an earlier add. Examples are a low digit sum of 16–18, where the nibble reads valid but H is set, and a carry out of a high digit that reads valid. To reach these cases, the stimulus loads random BCD operand pairs, adds them and then adjusts, so H and C come from the datapath itself rather than from a forced flag load. Directed flag loads then cover the C-set and H-set cases with otherwise valid digits. The rule that the X-mask may be cleared but never set is driven from both starting values of that bit.

// File: rtl/dualacc_datapath.sv
module dualacc_datapath #(
  parameter logic [7:0] CCR_RESET = 8'hD0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_sel,
  input  logic        ld_en,
  input  logic [2:0]  ld_sel,
  input  logic [15:0] ld_data,
  input  logic        ea_sel,
  input  logic [7:0]  ea_offset,
  output logic [15:0] ea_addr,
  output logic [7:0]  acc_a,
  output logic [7:0]  acc_b,
  output logic [15:0] acc_d,
  output logic [15:0] idx_x,
  output logic [15:0] idx_y,
  output logic [7:0]  ccr
);
  localparam int FC = 0, FV = 1, FZ = 2, FN = 3, FH = 5, FX = 6;

  logic [7:0]  a_q, b_q, f_q, a_n, b_n, f_n;
  logic [15:0] x_q, y_q, x_n, y_n;

  logic [8:0] sum9, dif9;
  logic [4:0] lo5;
  logic [7:0] dres;
  logic       adj_lo, adj_hi;

  assign sum9 = {1'b0, a_q} + {1'b0, b_q};
  assign dif9 = {1'b0, a_q} - {1'b0, b_q};
  assign lo5  = {1'b0, a_q[3:0]} + {1'b0, b_q[3:0]};

  assign adj_lo = f_q[FH] | (a_q[3:0] > 4'd9);
  assign adj_hi = f_q[FC] | (a_q[7:4] > 4'd9) | ((a_q[7:4] > 4'd8) & (a_q[3:0] > 4'd9));
  assign dres   = a_q + {(adj_hi ? 4'h6 : 4'h0), (adj_lo ? 4'h6 : 4'h0)};

  always_comb begin
    a_n = a_q; b_n = b_q; x_n = x_q; y_n = y_q; f_n = f_q;
    if (ld_en) begin
      case (ld_sel)
        3'd0: a_n = ld_data[7:0];
        3'd1: b_n = ld_data[7:0];
        3'd2: begin a_n = ld_data[15:8]; b_n = ld_data[7:0]; end
        3'd3: x_n = ld_data;
        3'd4: y_n = ld_data;
        3'd5: f_n = ld_data[7:0];
        default: ;
      endcase
    end else if (op_valid) begin
      case (op_sel)
        3'd0: begin
          a_n     = sum9[7:0];
          f_n[FH] = lo5[4];
          f_n[FN] = sum9[7];
          f_n[FZ] = (sum9[7:0] == 8'h00);
          f_n[FV] = (a_q[7] == b_q[7]) && (sum9[7] != a_q[7]);
          f_n[FC] = sum9[8];
        end
        3'd1, 3'd2: begin
          if (op_sel == 3'd1) a_n = dif9[7:0];
          f_n[FN] = dif9[7];
          f_n[FZ] = (dif9[7:0] == 8'h00);
          f_n[FV] = (a_q[7] != b_q[7]) && (dif9[7] != a_q[7]);
          f_n[FC] = dif9[8];
        end
        3'd3: x_n = x_q + {8'h00, b_q};
        3'd4: y_n = y_q + {8'h00, b_q};
        3'd5: begin
          f_n     = a_q;
          f_n[FX] = f_q[FX] & a_q[FX];
        end
        3'd6: a_n = f_q;
        default: begin
          a_n     = dres;
          f_n[FN] = dres[7];
          f_n[FZ] = (dres == 8'h00);
          f_n[FC] = adj_hi;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; x_q <= '0; y_q <= '0; f_q <= CCR_RESET;
    end else begin
      a_q <= a_n; b_q <= b_n; x_q <= x_n; y_q <= y_n; f_q <= f_n;
    end
  end

  assign acc_a   = a_q;
  assign acc_b   = b_q;
  assign acc_d   = {a_q, b_q};
  assign idx_x   = x_q;
  assign idx_y   = y_q;
  assign ccr     = f_q;
  assign ea_addr = (ea_sel ? y_q : x_q) + {8'h00, ea_offset};
endmodule

// File: rtl/dualacc_datapath_chk.sv
module dualacc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_sel,
  input logic        ld_en,
  input logic [2:0]  ld_sel,
  input logic [15:0] ld_data,
  input logic        ea_sel,
  input logic [7:0]  ea_offset,
  input logic [15:0] ea_addr,
  input logic [7:0]  acc_a,
  input logic [7:0]  acc_b,
  input logic [15:0] acc_d,
  input logic [15:0] idx_x,
  input logic [15:0] idx_y,
  input logic [7:0]  ccr
);
  logic run;
  assign run = op_valid && !ld_en;

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (ccr == 8'hD0 && acc_a == 8'h00 && acc_b == 8'h00 && idx_x == 16'h0 && idx_y == 16'h0));

  assert_add_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && op_sel == 3'd0 |=> acc_a == 8'($past(acc_a) + $past(acc_b)));

  assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run && op_sel == 3'd2 |=> acc_a == $past(acc_a) && acc_b == $past(acc_b));

  assert_index_add_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run && (op_sel == 3'd3 || op_sel == 3'd4) |=> ccr == $past(ccr));

  assert_xmask_never_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run && op_sel == 3'd5 && !ccr[6] |=> !ccr[6]);

  assert_flags_to_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && op_sel == 3'd6 |=> acc_a == $past(ccr) && $stable(ccr));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !ld_en |=> $stable(acc_d) && $stable(idx_x) && $stable(idx_y) && $stable(ccr));
endmodule

bind dualacc_datapath dualacc_datapath_chk u_chk (.*);

// File: tb/dualacc_datapath_tb.sv
module dualacc_datapath_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic        ea_sel = 1'b0;
  logic [7:0]  ea_offset = '0;
  logic [15:0] ea_addr, acc_d, idx_x, idx_y;
  logic [7:0]  acc_a, acc_b, ccr;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  logic [7:0]  m_a, m_b, m_f;
  logic [15:0] m_x, m_y;

  always #4 clk = ~clk;

  dualacc_datapath u_dut (.*);

  always @(posedge clk) begin
    int r, lo, hi, corr;
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_x = 0; m_y = 0; m_f = 8'hD0;
    end else if (ld_en) begin
      case (ld_sel)
        0: m_a = ld_data[7:0];
        1: m_b = ld_data[7:0];
        2: begin m_a = ld_data[15:8]; m_b = ld_data[7:0]; end
        3: m_x = ld_data;
        4: m_y = ld_data;
        5: m_f = ld_data[7:0];
        default: ;
      endcase
    end else if (op_valid) begin
      case (op_sel)
        0: begin
          r = int'(m_a) + int'(m_b);
          m_f[5] = ((m_a % 16) + (m_b % 16)) > 15;
          m_f[0] = r > 255;
          r = r % 256;
          m_f[1] = (m_a[7] == m_b[7]) && (r / 128 != int'(m_a[7]));
          m_f[3] = r >= 128; m_f[2] = (r == 0);
          m_a = r[7:0];
        end
        1, 2: begin
          r = (int'(m_a) - int'(m_b) + 256) % 256;
          m_f[0] = m_a < m_b;
          m_f[1] = (m_a[7] != m_b[7]) && (r / 128 != int'(m_a[7]));
          m_f[3] = r >= 128; m_f[2] = (r == 0);
          if (op_sel == 1) m_a = r[7:0];
        end
        3: m_x = 16'((int'(m_x) + int'(m_b)) % 65536);
        4: m_y = 16'((int'(m_y) + int'(m_b)) % 65536);
        5: m_f = {m_a[7], m_a[6] && m_f[6], m_a[5:0]};
        6: m_a = m_f;
        default: begin
          lo = m_a % 16; hi = m_a / 16; corr = 0;
          if (m_f[5] || lo > 9) corr += 6;
          if (m_f[0] || hi > 9 || (hi > 8 && lo > 9)) begin corr += 96; m_f[0] = 1; end
          else m_f[0] = 0;
          r = (int'(m_a) + corr) % 256;
          m_f[3] = r >= 128; m_f[2] = (r == 0);
          m_a = r[7:0];
        end
      endcase
    end
  end

  task automatic compare();
    logic [15:0] ea_exp;
    checks++;
    if (acc_a !== m_a || acc_b !== m_b || idx_x !== m_x || idx_y !== m_y || ccr !== m_f) begin
      errors++;
      $display("FAIL %s: got A=%h B=%h X=%h Y=%h F=%h expected A=%h B=%h X=%h Y=%h F=%h",
               tag, acc_a, acc_b, idx_x, idx_y, ccr, m_a, m_b, m_x, m_y, m_f);
    end
    checks++;
    if (acc_d !== {m_a, m_b}) begin
      errors++; $display("FAIL R2: D got %h expected %h", acc_d, {m_a, m_b});
    end
    ea_exp = (ea_sel ? m_y : m_x) + {8'h00, ea_offset};
    checks++;
    if (ea_addr !== ea_exp) begin
      errors++; $display("FAIL R10: ea got %h expected %h", ea_addr, ea_exp);
    end
  endtask

  function automatic string op_tag(logic [2:0] o);
    case (o)
      0: return "R3"; 1: return "R4"; 2: return "R5";
      3, 4: return "R6"; 5: return "R7"; 6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step(bit l, logic [2:0] ls, logic [15:0] ld, bit v, logic [2:0] o);
    @(negedge clk);
    compare();
    ld_en = l; ld_sel = ls; ld_data = ld; op_valid = v; op_sel = o;
    ea_sel = $urandom_range(0, 1); ea_offset = 8'($urandom);
    tag = l ? ((ls == 2) ? "R2" : "R11") : (v ? op_tag(o) : "R12");
  endtask

  task automatic load(logic [2:0] s, logic [15:0] d); step(1, s, d, 0, 0); endtask
  task automatic op(logic [2:0] o);                   step(0, 0, 0, 1, o); endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();                     // R1 reset state
    rst_n = 1'b1;
    load(2, 16'h1234);             // R2
    load(0, 16'hAA3C); load(1, 16'h0055); // R11
    load(3, 16'hFFF0); load(4, 16'h8000); load(5, 16'h0000);
    load(6, 16'hFFFF); load(7, 16'h0F0F); // R11 no effect
    load(2, 16'h7F01); op(0);      // R3 overflow, half carry
    load(2, 16'hFF01); op(0);      // R3 carry, zero
    load(2, 16'h0001); op(1);      // R4 borrow
    load(2, 16'h8001); op(1);      // R4 overflow
    load(2, 16'h4040); op(2);      // R5 equal
    load(2, 16'h1020); op(2);      // R5 borrow
    load(2, 16'h0020); op(3); op(4); // R6 wrap on X
    load(2, 16'hFF80); op(4); op(4);
    load(5, 16'h0000); load(0, 16'hFF); op(5); // R7 X stays clear
    load(5, 16'h0040); load(0, 16'h00); op(5); // R7 X clears
    load(5, 16'h00A5); op(6);      // R8
    load(5, 16'h0001); load(0, 16'h34); op(7); // R9 carry in
    load(5, 16'h0020); load(0, 16'h42); op(7); // R9 half carry in
    load(5, 16'h0000); load(0, 16'h9A); op(7); // R9 both nibbles
    step(1, 0, 16'h0011, 1, 0);    // R11 load wins over strobe
    repeat (4) step(0, 0, 0, 0, 0); // R12
    for (int i = 0; i < 60; i++) begin
      load(2, {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)),
               4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))});
      op(0); op(7);                // R9 after BCD add
    end
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 5) == 0, 3'($urandom), 16'($urandom),
           $urandom_range(0, 3) != 0, 3'($urandom));
    step(0, 0, 0, 0, 0);
    @(negedge clk); compare();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule